// File: doc/BRIEF.md
# 10BASE-T Heartbeat (SQE Test) Pulse Generator

This block produces the heartbeat pulse on the collision line toward the MAC after each packet sent in 10BASE-T operation. It watches the transmit enable for its falling edge. At that edge it checks four qualifying inputs: node (not repeater) operation, half duplex, link up and the heartbeat inhibit control clear. If all hold, it waits a fixed delay and then drives `col_sqe` high for a fixed window. Both the delay and the window are counted in bit times, where one bit time is 100 ns and spans `CLKS_PER_BIT` clock cycles.

The pulse is cancelled at once if a qualifying input stops holding while the pulse is pending or active. A new start of transmission during the delay also cancels it. Each falling edge produces at most one pulse. The output is meant to be ORed with the other collision sources by the surrounding logic.

Top module: `sqe_heartbeat`

## Requirements
- R1: While `rst` is high and after it is released, `col_sqe` is 0. A `tx_en` that is low at reset release, with no prior high, gives no pulse.
- R2: Let the edge that first samples `tx_en` low after a high be edge 0, and let D = `DELAY_BITS*CLKS_PER_BIT` and P = `PULSE_BITS*CLKS_PER_BIT`. If all conditions qualify, `col_sqe` is 1 after edges D through D+P-1 and 0 before and after that window.
- R3: No pulse is produced if, at the falling edge, any of these holds: `repeater_mode`=1, `full_duplex`=1, `link_ok`=0, `sqe_inhibit`=1. Each input is active high.
- R4: If any qualifying condition becomes false while a pulse is pending or active, `col_sqe` is 0 from the next clock edge on. The pulse does not resume when the condition returns.
- R5: If `tx_en` goes high during the delay, the pending pulse is cancelled. If it goes high during the pulse, the pulse runs to its full length.
- R6: A single falling edge of `tx_en` gives exactly one pulse. While `tx_en` stays low afterwards, `col_sqe` stays 0.
- R7: The counter never runs past the longer of the delay and pulse lengths.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmit enable from the MAC |
| repeater_mode | input | 1 | 1 = repeater operation (heartbeat disabled) |
| full_duplex | input | 1 | 1 = full duplex (heartbeat disabled) |
| link_ok | input | 1 | 1 = link valid |
| sqe_inhibit | input | 1 | 1 = heartbeat inhibited; 0 after reset by convention |
| col_sqe | output | 1 | Heartbeat collision pulse |

## Verification
The bench uses a small configuration and sweeps all sixteen combinations of the qualifying inputs. A design that ignored one of them would emit a pulse where none belongs. For each qualifying input, it drops that input at every cycle of the delay and of the pulse. A design that latched its decision at the edge would keep `col_sqe` high after the drop. It also raises `tx_en` at every one of those cycles. This exposes a design that lets a new frame cut a running pulse, or that ignores a restart during the delay. Long idle stretches after each pulse catch a generator that re-fires, or that resumes once the conditions come back.

// File: rtl/sqe_hb_pkg.sv
package sqe_hb_pkg;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_PULSE = 2'd2
  } hbState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic cntClr;
    logic cntInc;
  } hbCtrl_t;

  // Status from datapath to control
  typedef struct packed {
    logic fall;
    logic qualOk;
    logic txHigh;
    logic delayDone;
    logic pulseDone;
  } hbStat_t;

endpackage

// File: rtl/sqe_hb_datapath.sv
module sqe_hb_datapath
  import sqe_hb_pkg::*;
#(
  parameter int DELAY_CYC = 80,
  parameter int PULSE_CYC = 100
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    txEn,
  input  logic    repMode,
  input  logic    fullDup,
  input  logic    linkOk,
  input  logic    inhibit,
  input  hbCtrl_t ctrl,
  output hbStat_t stat
);

  localparam int MAX_CYC = (DELAY_CYC > PULSE_CYC) ? DELAY_CYC : PULSE_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             txPrev;
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) txPrev <= 1'b0;
    else     txPrev <= txEn;
  end

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (ctrl.cntClr) cnt <= '0;
    else if (ctrl.cntInc) cnt <= cnt + 1'b1;
  end

  always_comb begin
    stat.fall      = txPrev & ~txEn;
    stat.qualOk    = ~repMode & ~fullDup & linkOk & ~inhibit;
    stat.txHigh    = txEn;
    stat.delayDone = (cnt == CNT_W'(DELAY_CYC - 1));
    stat.pulseDone = (cnt == CNT_W'(PULSE_CYC - 1));
  end

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(MAX_CYC - 1));

endmodule

// File: rtl/sqe_hb_control.sv
module sqe_hb_control
  import sqe_hb_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  hbStat_t stat,
  output hbCtrl_t ctrl,
  output logic    colSqe
);

  hbState_t state, stateNxt;

  always_comb begin
    stateNxt    = state;
    ctrl.cntClr = 1'b0;
    ctrl.cntInc = 1'b0;
    case (state)
      HB_IDLE: begin
        if (stat.fall && stat.qualOk) begin
          stateNxt    = HB_WAIT;
          ctrl.cntClr = 1'b1;
        end
      end
      HB_WAIT: begin
        if (!stat.qualOk || stat.txHigh) begin
          stateNxt    = HB_IDLE;
          ctrl.cntClr = 1'b1;
        end else if (stat.delayDone) begin
          stateNxt    = HB_PULSE;
          ctrl.cntClr = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      HB_PULSE: begin
        if (!stat.qualOk || stat.pulseDone) begin
          stateNxt    = HB_IDLE;
          ctrl.cntClr = 1'b1;
        end else begin
          ctrl.cntInc = 1'b1;
        end
      end
      default: begin
        stateNxt    = HB_IDLE;
        ctrl.cntClr = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= HB_IDLE;
    else     state <= stateNxt;
  end

  assign colSqe = (state == HB_PULSE);

  // R5
  wait_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (state == HB_WAIT && stat.txHigh) |=> (state == HB_IDLE));

  // R4
  qual_loss_chk: assert property (@(posedge clk) disable iff (rst)
    (state != HB_IDLE && !stat.qualOk) |=> !colSqe);

  // R2
  pulse_entry_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(colSqe) |-> ($past(state) == HB_WAIT && $past(stat.delayDone)));

  // R6
  single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(colSqe) |=> !colSqe);

endmodule

// File: rtl/sqe_heartbeat.sv
module sqe_heartbeat
  import sqe_hb_pkg::*;
#(
  parameter int CLKS_PER_BIT = 10,
  parameter int DELAY_BITS   = 8,
  parameter int PULSE_BITS   = 10
) (
  input  logic clk,
  input  logic rst,
  input  logic tx_en,
  input  logic repeater_mode,
  input  logic full_duplex,
  input  logic link_ok,
  input  logic sqe_inhibit,
  output logic col_sqe
);

  localparam int DELAY_CYC = DELAY_BITS * CLKS_PER_BIT;
  localparam int PULSE_CYC = PULSE_BITS * CLKS_PER_BIT;

  hbCtrl_t ctrl;
  hbStat_t stat;

  sqe_hb_datapath #(
    .DELAY_CYC(DELAY_CYC),
    .PULSE_CYC(PULSE_CYC)
  ) u_dp (
    .clk    (clk),
    .rst    (rst),
    .txEn   (tx_en),
    .repMode(repeater_mode),
    .fullDup(full_duplex),
    .linkOk (link_ok),
    .inhibit(sqe_inhibit),
    .ctrl   (ctrl),
    .stat   (stat)
  );

  sqe_hb_control u_ctl (
    .clk   (clk),
    .rst   (rst),
    .stat  (stat),
    .ctrl  (ctrl),
    .colSqe(col_sqe)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !col_sqe);

endmodule

// File: tb/sqe_heartbeat_tb.sv
module sqe_heartbeat_tb;

  localparam int CPB = 2;
  localparam int DB  = 3;
  localparam int PB  = 2;
  localparam int D   = DB * CPB;
  localparam int P   = PB * CPB;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic txEn = 1'b0;
  logic rep = 1'b0, fd = 1'b0, lnk = 1'b1, inh = 1'b0;
  logic col;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  sqe_heartbeat #(.CLKS_PER_BIT(CPB), .DELAY_BITS(DB), .PULSE_BITS(PB)) u_dut (
    .clk(clk), .rst(rst), .tx_en(txEn), .repeater_mode(rep),
    .full_duplex(fd), .link_ok(lnk), .sqe_inhibit(inh), .col_sqe(col)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000) begin
      errors = errors + 1;
      $display("FAIL watchdog: actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string tag, input int j, input logic exp);
    checks++;
    if (col !== exp) begin
      errors++;
      $display("FAIL %s step=%0d actual=%0b expected=%0b", tag, j, col, exp);
    end
  endtask

  task automatic setGood();
    rep = 1'b0; fd = 1'b0; lnk = 1'b1; inh = 1'b0;
  endtask

  task automatic dropCond(input int kind);
    case (kind)
      0: rep = 1'b1;
      1: fd  = 1'b1;
      2: lnk = 1'b0;
      default: inh = 1'b1;
    endcase
  endtask

  // cfg = {inh, lnk, fd, rep}; dropAt/riseAt = 0 means unused
  task automatic runFrame(input logic [3:0] cfg, input int dropAt,
                          input int dropKind, input int riseAt);
    logic qual;
    string tag;
    @(negedge clk);
    rep = cfg[0]; fd = cfg[1]; lnk = cfg[2]; inh = cfg[3];
    txEn = 1'b1;
    repeat (3) @(negedge clk);
    qual = !cfg[0] && !cfg[1] && cfg[2] && !cfg[3];
    if (dropAt > 0)      tag = "R4";
    else if (riseAt > 0) tag = "R5";
    else if (qual)       tag = "R2";
    else                 tag = "R3";
    txEn = 1'b0;
    for (int j = 1; j <= D + P + 3; j++) begin
      logic exp;
      @(negedge clk);
      exp = qual && (j > D) && (j <= D + P);
      if (dropAt > 0 && j > dropAt) exp = 1'b0;
      if (riseAt > 0 && riseAt <= D && j > riseAt) exp = 1'b0;
      check(tag, j, exp);
      if (j == dropAt) dropCond(dropKind);
      if (j == riseAt) txEn = 1'b1;
    end
    // R6: no second pulse, no resume once conditions return
    setGood();
    for (int j = 0; j < D + P + 2; j++) begin
      @(negedge clk);
      check("R6", j, 1'b0);
    end
  endtask

  initial begin
    setGood();
    txEn = 1'b0;
    repeat (3) @(negedge clk);
    // R1: quiet during reset
    check("R1", 0, 1'b0);
    rst = 1'b0;
    // R1: low tx_en at reset release with no prior high gives nothing
    for (int j = 1; j <= D + P + 4; j++) begin
      @(negedge clk);
      check("R1", j, 1'b0);
    end

    // R2 / R3: every combination of the qualifying inputs
    for (int c = 0; c < 16; c++) runFrame(4'(c), 0, 0, 0);

    // R4: drop each condition at each step of delay and pulse
    for (int k = 0; k < 4; k++)
      for (int a = 1; a <= D + P; a++)
        runFrame(4'b0100, a, k, 0);

    // R5: tx_en restart at each step of delay and pulse
    for (int a = 1; a <= D + P; a++) runFrame(4'b0100, 0, 0, a);

    // R2 again after the sweeps: plain qualified frame
    runFrame(4'b0100, 0, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule